// File: doc/BRIEF.md
# Two-Bank Command Decoder and Timing Guard

This block sits on the command side of a synchronous graphics DRAM controller that drives a memory with two internal banks. On each rising clock edge it samples the active-low chip select, row strobe, column strobe and write enable, the special-function line, a bank-select bit and the address bus. It classifies the command and checks it against the current state of the target bank and the cycle spacing rules. One cycle later it reports a command code, an accept flag or an error flag.

For each bank the block records whether the bank is idle or active. It also records whether writes to that bank are masked: this mode is set by the special-function line when the bank is activated, and later writes to the bank use it. Every spacing limit is a parameter counted in clock cycles:
- activate to read or write;
- activate to activate on the same bank;
- activate to activate across the two banks;
- the minimum and maximum time a bank may stay open.

A command that breaks a rule is refused and changes no state. A bank held open past its maximum time raises a sticky overrun flag.

Top module: `sgram_cmd_guard`

## Requirements
- R1: The command code output uses these values: 0 no-op, 1 activate, 2 single-bank precharge, 3 precharge of both banks, 4 read, 5 unmasked write, 6 masked write, 7 any other encoding. The encodings are given with chip select low and as (ras_n, cas_n, we_n). Activate is (0,1,1) with any dsf. Precharge is (0,1,0) with dsf low. Read is (1,0,1) with dsf low. Write is (1,0,0) with dsf low. Every remaining encoding, such as (0,0,1) or a read with dsf high, is code 7 and is accepted without any state change.
- R2: An activate to an idle bank, with the spacing rules met, is accepted. The bank becomes active and its mask mode takes the value of dsf: bit b of bank_masked is 1 when dsf was high.
- R3: An activate to a bank that is already active raises the error flag. Neither the state nor the mask mode of that bank changes.
- R4: An activate is refused when fewer than T_RC cycles have passed since the last activate of the same bank, or fewer than T_RRD cycles since the last activate of either bank.
- R5: A read or write is accepted only if its bank is active and at least T_RCD cycles have passed since that bank's activate. A write reports code 6 when the bank was activated with dsf high, and code 5 otherwise.
- R6: A single-bank precharge (addr bit AP_BIT low) of an active bank is accepted only when at least T_RAS_MIN cycles have passed since its activate, and it makes the bank idle. A precharge to an idle bank is accepted and changes nothing.
- R7: A precharge with addr bit AP_BIT high closes both banks. It is accepted when every active bank has met T_RAS_MIN, including when one or both banks are already idle. Otherwise it is refused and neither bank changes.
- R8: The outputs are registered: results appear one cycle after the command is sampled. Accept and error are never high together, and error is a one-cycle pulse per refused command.
- R9: Let the activate be cycle 0. If the bank is still open after command cycle T_RAS_MAX, its tras_overrun bit goes high. A precharge accepted in cycle T_RAS_MAX or earlier prevents this. The flag stays high until the bank is precharged or activated again.
- R10: Chip select high, or ras_n, cas_n and we_n all high, is a no-op. It gives code 0 with accept and error both low, and it changes no state.
- R11: After a synchronous reset with rst_n low, both banks are idle and unmasked, no overrun is flagged, the code is 0, and accept and error are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| dsf | input | 1 | Special-function line |
| bank_sel | input | 1 | Target bank |
| addr | input | ADDR_W | Address bus; bit AP_BIT selects both-bank precharge |
| cmd_code | output | 3 | Registered command code (R1 values) |
| cmd_accept | output | 1 | Registered: command was legal and applied |
| cmd_error | output | 1 | Registered: command was refused |
| bank_active | output | 2 | Per-bank active state |
| bank_masked | output | 2 | Per-bank masked-write mode |
| tras_overrun | output | 2 | Per-bank open-too-long flag |

## Verification
The overrun window is the hardest case to reach from the ports. It needs a bank held open for exactly T_RAS_MAX command cycles with no precharge. It also needs a contrasting run in which the precharge arrives in the very last permitted cycle. The bench builds both runs from a counted stream of no-ops after a single activate. Every spacing limit is swept one gap at a time around its threshold, with a reset before each gap, so that each point begins from a known bank history. The expected accept or error result at each point is computed by comparing the gap with the parameter.

// File: rtl/sgram_guard_pkg.sv
// Shared command codes for the two-bank command guard.
package sgram_guard_pkg;

    // Command classes; the numeric values appear on the cmd_code port.
    typedef enum logic [2:0] {
        CMD_NOP       = 3'd0,
        CMD_ACT       = 3'd1,
        CMD_PRE       = 3'd2,
        CMD_PREALL    = 3'd3,
        CMD_READ      = 3'd4,
        CMD_WRITE     = 3'd5,
        CMD_WRITE_MSK = 3'd6,
        CMD_OTHER     = 3'd7
    } cmd_code_e;

endpackage

// File: rtl/sgram_cmd_decode.sv
// Combinational classifier of the sampled command strobes.
// Assumes: all inputs are already registered or stable at the sampling edge.
// It never returns CMD_WRITE_MSK: the mask mode is resolved later from bank state.
module sgram_cmd_decode
    import sgram_guard_pkg::*;
(
    input  logic      cs_n,
    input  logic      ras_n,
    input  logic      cas_n,
    input  logic      we_n,
    input  logic      dsf,
    input  logic      ap,
    output cmd_code_e kind
);

    // Map the strobe pattern to a command class.
    always_comb begin
        kind = CMD_OTHER;
        if (cs_n) begin
            kind = CMD_NOP;
        end else begin
            unique case ({ras_n, cas_n, we_n})
                3'b111: kind = CMD_NOP;
                3'b011: kind = CMD_ACT;
                3'b010: kind = dsf ? CMD_OTHER : (ap ? CMD_PREALL : CMD_PRE);
                3'b101: kind = dsf ? CMD_OTHER : CMD_READ;
                3'b100: kind = dsf ? CMD_OTHER : CMD_WRITE;
                default: kind = CMD_OTHER;
            endcase
        end
    end

endmodule

// File: rtl/sgram_act_spacing.sv
// Cross-bank activate spacing counter.
// It counts the cycles since the most recent accepted activate to any bank and
// saturates at T_RRD. Assumes act_fire only pulses when act_ok was high.
module sgram_act_spacing #(
    parameter int T_RRD = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act_fire,
    output logic act_ok
);

    localparam int GAP_W = $clog2(T_RRD + 1) + 1;

    logic [GAP_W-1:0] gap_q;

    // Restart on an activate, otherwise count up to the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q <= GAP_W'(T_RRD);
        end else if (act_fire) begin
            gap_q <= GAP_W'(1);
        end else if (gap_q < GAP_W'(T_RRD)) begin
            gap_q <= gap_q + GAP_W'(1);
        end
    end

    assign act_ok = (gap_q >= GAP_W'(T_RRD));

    // The top must never issue an activate inside the shared window.
    assert_cross_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        act_fire |-> gap_q >= GAP_W'(T_RRD));

endmodule

// File: rtl/sgram_bank_track.sv
// State and timing of one bank.
// Tracks idle or active state and the masked-write mode. Counts the cycles since
// the last activate (saturating) and the remaining open time down to T_RAS_MAX.
// Reports which commands are currently legal for this bank.
// Assumes do_act and do_pre are never high together.
module sgram_bank_track #(
    parameter int T_RCD     = 3,
    parameter int T_RC      = 8,
    parameter int T_RAS_MIN = 5,
    parameter int T_RAS_MAX = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic do_act,
    input  logic do_pre,
    input  logic rw_fire,
    input  logic masked_in,
    output logic active,
    output logic masked,
    output logic overrun,
    output logic act_ok,
    output logic rcd_ok,
    output logic ras_ok
);

    localparam int SAT_A  = (T_RC > T_RAS_MIN) ? T_RC : T_RAS_MIN;
    localparam int SAT    = (SAT_A > T_RCD) ? SAT_A : T_RCD;
    localparam int CNT_W  = $clog2(SAT + 1) + 1;
    localparam int REM_W  = $clog2(T_RAS_MAX + 1) + 1;

    logic [CNT_W-1:0] since_q;
    logic [REM_W-1:0] rem_q;

    // Open or close the bank; latch the mask mode at activate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            masked <= 1'b0;
        end else if (do_act) begin
            active <= 1'b1;
            masked <= masked_in;
        end else if (do_pre) begin
            active <= 1'b0;
        end
    end

    // Cycles since the last activate, saturating at the largest limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_q <= CNT_W'(SAT);
        end else if (do_act) begin
            since_q <= CNT_W'(1);
        end else if (since_q < CNT_W'(SAT)) begin
            since_q <= since_q + CNT_W'(1);
        end
    end

    // Remaining open time before the maximum is exceeded.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
        end else if (do_act) begin
            rem_q <= REM_W'(T_RAS_MAX - 1);
        end else if (active && rem_q != '0) begin
            rem_q <= rem_q - REM_W'(1);
        end
    end

    // Sticky overrun flag, cleared when the bank is closed or reopened.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overrun <= 1'b0;
        end else if (do_act || do_pre) begin
            overrun <= 1'b0;
        end else if (active && rem_q == '0) begin
            overrun <= 1'b1;
        end
    end

    assign act_ok = !active && (since_q >= CNT_W'(T_RC));
    assign rcd_ok = active && (since_q >= CNT_W'(T_RCD));
    assign ras_ok = !active || (since_q >= CNT_W'(T_RAS_MIN));

    // An accepted activate must find this bank idle.
    assert_act_from_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        do_act |-> !active);

    // Closing an open bank must respect the minimum open time.
    assert_pre_after_min_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (do_pre && active) |-> since_q >= CNT_W'(T_RAS_MIN));

    // Column access only on an open bank past the row-to-column delay.
    assert_rw_after_rcd_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rw_fire |-> (active && since_q >= CNT_W'(T_RCD)));

    // Overrun can only be shown while the bank is open.
    assert_overrun_open_R9: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> active);

endmodule

// File: rtl/sgram_cmd_guard.sv
// Two-bank command decoder and timing guard (top).
// Samples the command strobes every rising edge, checks each command against
// the bank state and spacing rules, applies legal commands to the bank trackers,
// and registers the code, accept and error results one cycle later.
// Assumes: two banks selected by bank_sel; all limits are given in clock cycles.
module sgram_cmd_guard
    import sgram_guard_pkg::*;
#(
    parameter int ADDR_W    = 11,
    parameter int AP_BIT    = 8,
    parameter int T_RCD     = 3,
    parameter int T_RC      = 8,
    parameter int T_RRD     = 2,
    parameter int T_RAS_MIN = 5,
    parameter int T_RAS_MAX = 12000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic              dsf,
    input  logic              bank_sel,
    input  logic [ADDR_W-1:0] addr,
    output logic [2:0]        cmd_code,
    output logic              cmd_accept,
    output logic              cmd_error,
    output logic [1:0]        bank_active,
    output logic [1:0]        bank_masked,
    output logic [1:0]        tras_overrun
);

    localparam int NUM_BANKS = 2;

    cmd_code_e            kind;
    cmd_code_e            code_d;
    logic                 legal;
    logic                 spacing_ok;
    logic                 act_fire;
    logic [NUM_BANKS-1:0] act_ok;
    logic [NUM_BANKS-1:0] rcd_ok;
    logic [NUM_BANKS-1:0] ras_ok;
    logic [NUM_BANKS-1:0] do_act;
    logic [NUM_BANKS-1:0] do_pre;
    logic [NUM_BANKS-1:0] rw_fire;

    sgram_cmd_decode u_decode (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .dsf   (dsf),
        .ap    (addr[AP_BIT]),
        .kind  (kind)
    );

    // Legality of the sampled command against bank state and spacing.
    always_comb begin
        unique case (kind)
            CMD_ACT:             legal = act_ok[bank_sel] && spacing_ok;
            CMD_PRE:             legal = ras_ok[bank_sel];
            CMD_PREALL:          legal = &ras_ok;
            CMD_READ, CMD_WRITE: legal = rcd_ok[bank_sel];
            default:             legal = 1'b1;
        endcase
    end

    // Resolve writes to their masked or unmasked form from the bank mode.
    always_comb begin
        code_d = kind;
        if (kind == CMD_WRITE && bank_masked[bank_sel]) begin
            code_d = CMD_WRITE_MSK;
        end
    end

    assign act_fire = (kind == CMD_ACT) && legal;

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            logic hit;
            assign hit        = (bank_sel == 1'(b));
            assign do_act[b]  = act_fire && hit;
            assign do_pre[b]  = legal && ((kind == CMD_PRE && hit) || kind == CMD_PREALL);
            assign rw_fire[b] = legal && hit && (kind == CMD_READ || kind == CMD_WRITE);

            sgram_bank_track #(
                .T_RCD     (T_RCD),
                .T_RC      (T_RC),
                .T_RAS_MIN (T_RAS_MIN),
                .T_RAS_MAX (T_RAS_MAX)
            ) u_bank (
                .clk       (clk),
                .rst_n     (rst_n),
                .do_act    (do_act[b]),
                .do_pre    (do_pre[b]),
                .rw_fire   (rw_fire[b]),
                .masked_in (dsf),
                .active    (bank_active[b]),
                .masked    (bank_masked[b]),
                .overrun   (tras_overrun[b]),
                .act_ok    (act_ok[b]),
                .rcd_ok    (rcd_ok[b]),
                .ras_ok    (ras_ok[b])
            );
        end
    endgenerate

    sgram_act_spacing #(
        .T_RRD (T_RRD)
    ) u_spacing (
        .clk      (clk),
        .rst_n    (rst_n),
        .act_fire (act_fire),
        .act_ok   (spacing_ok)
    );

    // Register the per-command result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_code   <= CMD_NOP;
            cmd_accept <= 1'b0;
            cmd_error  <= 1'b0;
        end else begin
            cmd_code   <= code_d;
            cmd_accept <= (kind != CMD_NOP) && legal;
            cmd_error  <= (kind != CMD_NOP) && !legal;
        end
    end

    // Accept and error are exclusive outcomes.
    assert_one_outcome_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_accept && cmd_error));

    // A refused command leaves the bank state where it was.
    assert_error_no_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_error |-> ($stable(bank_active) && $stable(bank_masked)));

    // A no-op produces no result and touches no state.
    assert_nop_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == CMD_NOP) |=> (!cmd_accept && !cmd_error && $stable(bank_active)));

    // Both-bank precharge is only accepted when both trackers allow it.
    assert_preall_both_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (do_pre == 2'b11) |=> (bank_active == 2'b00));

endmodule

// File: tb/sgram_cmd_guard_tb.sv
// Self-checking bench: threshold sweeps over every spacing limit with a small
// parameter set. Inputs change on the falling edge; results are read one falling
// edge later, after the single register stage.
module sgram_cmd_guard_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 11;
    localparam int AP_BIT     = 8;
    localparam int T_RCD      = 3;
    localparam int T_RC       = 8;
    localparam int T_RRD      = 2;
    localparam int T_RAS_MIN  = 5;
    localparam int T_RAS_MAX  = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cs_n = 1'b1;
    logic              ras_n = 1'b1;
    logic              cas_n = 1'b1;
    logic              we_n = 1'b1;
    logic              dsf = 1'b0;
    logic              bank_sel = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [2:0]        cmd_code;
    logic              cmd_accept;
    logic              cmd_error;
    logic [1:0]        bank_active;
    logic [1:0]        bank_masked;
    logic [1:0]        tras_overrun;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sgram_cmd_guard #(
        .ADDR_W    (ADDR_W),
        .AP_BIT    (AP_BIT),
        .T_RCD     (T_RCD),
        .T_RC      (T_RC),
        .T_RRD     (T_RRD),
        .T_RAS_MIN (T_RAS_MIN),
        .T_RAS_MAX (T_RAS_MAX)
    ) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cs_n         (cs_n),
        .ras_n        (ras_n),
        .cas_n        (cas_n),
        .we_n         (we_n),
        .dsf          (dsf),
        .bank_sel     (bank_sel),
        .addr         (addr),
        .cmd_code     (cmd_code),
        .cmd_accept   (cmd_accept),
        .cmd_error    (cmd_error),
        .bank_active  (bank_active),
        .bank_masked  (bank_masked),
        .tras_overrun (tras_overrun)
    );

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            n_fails = n_fails + 1;
            $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 100000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    task automatic chk(input string req, input int actual, input int expected);
        n_checks++;
        if (actual != expected) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    // Present one command and wait until its result is visible.
    task automatic drive(input logic c, input logic r, input logic ca, input logic w,
                         input logic d, input logic b, input logic ap);
        cs_n = c; ras_n = r; cas_n = ca; we_n = w; dsf = d; bank_sel = b;
        addr = '0;
        addr[AP_BIT] = ap;
        @(negedge clk);
    endtask

    task automatic nop();                     drive(0,1,1,1,0,0,0); endtask
    task automatic nops(input int n);         for (int i = 0; i < n; i++) nop(); endtask
    task automatic act(input logic b, input logic d); drive(0,0,1,1,d,b,0); endtask
    task automatic pre(input logic b);        drive(0,0,1,0,0,b,0); endtask
    task automatic preall();                  drive(0,0,1,0,0,0,1); endtask
    task automatic rd(input logic b);         drive(0,1,0,1,0,b,0); endtask
    task automatic wr(input logic b);         drive(0,1,0,0,0,b,0); endtask

    task automatic do_reset();
        cs_n = 1'b1; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1;
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        @(negedge clk);
        do_reset();

        // R11: reset state
        chk("R11 code", cmd_code, 0);
        chk("R11 accept", cmd_accept, 0);
        chk("R11 error", cmd_error, 0);
        chk("R11 active", bank_active, 0);
        chk("R11 masked", bank_masked, 0);
        chk("R11 overrun", tras_overrun, 0);

        // R10: chip select high carrying an activate pattern, then an all-high no-op
        drive(1,0,1,1,1,0,0);
        chk("R10 code", cmd_code, 0);
        chk("R10 accept", cmd_accept, 0);
        chk("R10 error", cmd_error, 0);
        chk("R10 active", bank_active, 0);
        drive(0,1,1,1,1,1,0);
        chk("R10 nop code", cmd_code, 0);
        chk("R10 nop accept", cmd_accept, 0);
        chk("R10 nop masked", bank_masked, 0);

        // R1: other encodings and single precharge of an idle bank (R6)
        drive(0,0,0,1,0,0,0);
        chk("R1 refresh code", cmd_code, 7);
        chk("R1 refresh accept", cmd_accept, 1);
        drive(0,1,0,1,1,0,0);
        chk("R1 dsf read code", cmd_code, 7);
        chk("R1 dsf read active", bank_active, 0);
        pre(1);
        chk("R6 idle pre code", cmd_code, 2);
        chk("R6 idle pre accept", cmd_accept, 1);
        chk("R6 idle pre active", bank_active, 0);
        rd(0);
        chk("R5 read idle bank error", cmd_error, 1);
        chk("R1 read code", cmd_code, 4);

        // R5: activate-to-column sweep on both banks
        for (int b = 0; b < 2; b++) begin
            for (int g = 1; g <= T_RCD + 2; g++) begin
                do_reset();
                act(1'(b), 0);
                chk("R1 act code", cmd_code, 1);
                nops(g - 1);
                rd(1'(b));
                chk("R5 read gap error", cmd_error, (g < T_RCD) ? 1 : 0);
                chk("R5 read gap accept", cmd_accept, (g < T_RCD) ? 0 : 1);
                chk("R8 error pulse", int'(cmd_error & cmd_accept), 0);
                nop();
                chk("R8 error one cycle", cmd_error, 0);
            end
        end

        // R6: minimum open time sweep
        for (int b = 0; b < 2; b++) begin
            for (int g = 1; g <= T_RAS_MIN + 1; g++) begin
                do_reset();
                act(1'(b), 0);
                nops(g - 1);
                pre(1'(b));
                chk("R6 pre gap error", cmd_error, (g < T_RAS_MIN) ? 1 : 0);
                chk("R6 pre gap active", bank_active[b], (g < T_RAS_MIN) ? 1 : 0);
            end
        end

        // R4: same-bank activate cycle sweep (precharge at the minimum open time)
        for (int g = T_RAS_MIN + 1; g <= T_RC + 1; g++) begin
            do_reset();
            act(0, 0);
            nops(T_RAS_MIN - 1);
            pre(0);
            nops(g - T_RAS_MIN - 1);
            act(0, 0);
            chk("R4 same-bank error", cmd_error, (g < T_RC) ? 1 : 0);
            chk("R4 same-bank active", bank_active[0], (g < T_RC) ? 0 : 1);
        end

        // R4: cross-bank activate sweep
        for (int g = 1; g <= T_RRD + 2; g++) begin
            do_reset();
            act(0, 0);
            nops(g - 1);
            act(1, 0);
            chk("R4 cross-bank error", cmd_error, (g < T_RRD) ? 1 : 0);
            chk("R4 cross-bank active", bank_active, (g < T_RRD) ? 1 : 3);
        end

        // R2, R5, R3: mask mode latch, write codes, activate to open bank
        do_reset();
        act(0, 1);
        chk("R2 active", bank_active, 1);
        chk("R2 masked", bank_masked, 1);
        nops(T_RRD);
        act(1, 0);
        chk("R2 second active", bank_active, 3);
        chk("R2 second masked", bank_masked, 1);
        nops(T_RCD);
        wr(0);
        chk("R5 masked write code", cmd_code, 6);
        wr(1);
        chk("R5 plain write code", cmd_code, 5);
        act(0, 0);
        chk("R3 reopen error", cmd_error, 1);
        chk("R3 reopen masked", bank_masked, 1);
        chk("R3 reopen active", bank_active, 3);
        preall();
        chk("R7 preall accept", cmd_accept, 1);
        chk("R7 preall code", cmd_code, 3);
        chk("R7 preall active", bank_active, 0);

        // R7: both-bank precharge blocked by one young bank
        do_reset();
        act(0, 0);
        nops(T_RAS_MIN);
        act(1, 0);
        preall();
        chk("R7 young bank error", cmd_error, 1);
        chk("R7 young bank active", bank_active, 3);
        nops(T_RAS_MIN - 2);
        preall();
        chk("R7 matured accept", cmd_accept, 1);
        chk("R7 matured active", bank_active, 0);
        preall();
        chk("R7 idle preall accept", cmd_accept, 1);

        // R9: open-time overrun and its boundary
        do_reset();
        act(1, 0);
        nops(T_RAS_MAX - 1);
        chk("R9 no overrun before limit", tras_overrun, 0);
        nop();
        chk("R9 overrun at limit", tras_overrun, 2);
        nop();
        chk("R9 overrun sticky", tras_overrun, 2);
        pre(1);
        chk("R9 overrun cleared", tras_overrun, 0);
        chk("R9 closed", bank_active, 0);
        act(1, 0);
        nops(T_RAS_MAX - 1);
        pre(1);
        chk("R9 last-cycle pre", tras_overrun, 0);
        nop();
        chk("R9 no late overrun", tras_overrun, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule